// File: doc/BRIEF.md
# Input Pin Interrupt and Reset Conditioner

This block conditions a small group of input pins for the rest of a microcontroller-style subsystem. Each pin is brought into the clock domain through a synchronizer. It can then be routed to the interrupt logic either directly or through a debouncer that is paced by an external tick. Each pin carries its own polarity choice. The polarity decides which edge raises a write-one-to-clear interrupt flag, and it also sets the sense of the pin when the pin is used as a clock tap for an event counter. Each pin also has a mask bit.

Two pins always pass through the debouncer and feed software-visible test variables, whatever the interrupt path selects. The block also forms a reset request from a programmable combination of the synchronized pins. Each pin contributes a term chosen by a two-bit code. A build parameter joins the terms with AND or with OR. The request is raised only once the combination has held for a programmable number of clock cycles.

Top module: `inport_cond`

## Requirements
- R1: In bypass mode (debounce select 0) a rising pin edge sets its flag on the third rising clock edge after the pin changes, counting the two synchronizer stages.
- R2: With debounce selected, a new pin level is accepted only when the synchronized pin has the same value at two consecutive clock cycles in which `deb_tick` is high. A level that does not last across two ticks is never accepted.
- R3: `test_var[0]` and `test_var[1]` are the debounced levels of pins 0 and 1, even when `cfg_deb_en` selects bypass for those pins.
- R4: `cfg_edge_fall[i]` = 0 makes a rising edge of pin i set its flag. A value of 1 makes a falling edge set it. The opposite edge has no effect on the flag.
- R5: An edge seen while `cfg_mask_open[i]` = 0 is not stored. Opening the mask afterwards sets no flag; only the next active edge does.
- R6: A write with `wr_en` = 1 clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 are unchanged.
- R7: `irq_any` is high exactly when some flag is set and its mask bit is 1. A set flag whose mask is closed stays set but does not drive `irq_any`.
- R8: Changing `cfg_edge_fall[i]` while the mask is open can itself act as an edge. With pin i low, switching the bit from 0 to 1 sets flag i on the next clock edge.
- R9: `cnt_tap[0]` is the conditioned pin 0 XOR `cfg_edge_fall[0]`. `cnt_tap[1]` is the conditioned top pin XOR its `cfg_edge_fall` bit.
- R10: The reset term of pin i is selected by `cfg_rst_sel[2i+1:2i]`: 00 gives constant 0, 01 gives the pin, 10 gives the inverted pin, 11 gives constant 1.
- R11: With `RST_USE_AND` = 1 the terms are ANDed, so all codes 11 always request reset. With `RST_USE_AND` = 0 the terms are ORed.
- R12: `rst_req` rises only after the combination has been true for `RST_HOLD` consecutive clock edges. It falls on the first clock edge after the combination goes false.
- R13: After reset, all flags, `irq_any`, `test_var` and `rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 4 | Asynchronous input pins |
| deb_tick | input | 1 | One-cycle debouncer clock enable |
| cfg_deb_en | input | 4 | Per pin: 1 routes the debounced level to interrupts and taps |
| cfg_edge_fall | input | 4 | Per pin polarity: 0 rising, 1 falling |
| cfg_mask_open | input | 4 | Per pin: 1 allows a flag to be stored |
| cfg_rst_sel | input | 8 | Two-bit reset term code per pin |
| wr_en | input | 1 | Flag clear write strobe |
| wr_data | input | 4 | Write-one-to-clear data |
| irq_flag | output | 4 | Interrupt flags |
| irq_any | output | 1 | Combined unmasked interrupt |
| test_var | output | 2 | Debounced pins 0 and 1 |
| cnt_tap | output | 2 | Polarity-adjusted pin 0 and top pin for the event counter |
| rst_req | output | 1 | Reset request after the hold interval |

## Verification
On every cycle, the assertions check these properties:
- a flag rises only when its mask was open and falls only because of a clear write;
- `irq_any` is never high without a flag;
- test variables move only on a tick;
- `rst_req` never appears before the condition has run for the full hold count.

Only the bench scenarios can show the rest:
- the exact edge latency through the synchronizer;
- polarity choice and the spurious request on a polarity change;
- that opening the mask does not pick up an old edge;
- rejection of a one-tick glitch;
- the reset term truth table under both AND and OR joining.

// File: rtl/inport_pkg.sv
// Shared types for the input conditioner: reset term codes and their evaluation.
package inport_pkg;

    typedef enum logic [1:0] {
        TERM_ZERO = 2'b00,
        TERM_PIN  = 2'b01,
        TERM_INV  = 2'b10,
        TERM_ONE  = 2'b11
    } term_code_e;

    // Evaluate one reset term from its two-bit code and the pin level.
    function automatic logic term_eval(input logic [1:0] code, input logic pin);
        logic res;
        case (term_code_e'(code))
            TERM_ZERO: res = 1'b0;
            TERM_PIN:  res = pin;
            TERM_INV:  res = ~pin;
            default:   res = 1'b1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/inport_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no multi-bit coherence is claimed.
module inport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin vector through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/inport_debounce.sv
// Tick-paced debouncer: a bit's output takes a new level only when the
// input shows that level on two consecutive tick cycles.
// Assumes the input is already synchronous to clk.
module inport_debounce #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] prev;
    logic [W-1:0] stable;

    assign stable = ~(din ^ prev);

    // On each tick, remember the sample and accept bits equal to the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            dout <= '0;
        end else if (tick) begin
            prev <= din;
            dout <= (stable & din) | (~stable & dout);
        end
    end
endmodule

// File: rtl/inport_edge_flags.sv
// Per-pin polarity, edge detection and write-one-to-clear flag storage.
// An edge is stored only while its mask bit is open; a set and a clear in the
// same cycle leave the flag set so no event is lost.
module inport_edge_flags #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] fall_sel,
    input  logic [W-1:0] mask_open,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] pol,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic pol_d;
        logic hit;
        logic clr;

        assign pol[i] = level[i] ^ fall_sel[i];
        assign hit    = pol[i] & ~pol_d & mask_open[i];
        assign clr    = clr_en & clr_data[i];

        // Track the polarized level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) pol_d <= 1'b0;
            else        pol_d <= pol[i];
        end

        // Set on an unmasked active edge, clear on a write of one.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~clr) | hit;
        end
    end
endmodule

// File: rtl/inport_rst_comb.sv
// Programmable reset combination with a hold counter.
// Each pin contributes a term by its two-bit code. The terms are joined by AND
// or OR per parameter, and the request is issued after HOLD consecutive true cycles.
module inport_rst_comb
    import inport_pkg::*;
#(
    parameter int W       = 4,
    parameter bit USE_AND = 1'b1,
    parameter int HOLD    = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   level,
    input  logic [2*W-1:0] sel,
    output logic           cond,
    output logic           req
);
    localparam int CW = $clog2(HOLD + 1);

    logic [W-1:0]  term;
    logic [CW-1:0] cnt;

    for (genvar i = 0; i < W; i++) begin : g_term
        assign term[i] = term_eval(sel[2*i +: 2], level[i]);
    end

    if (USE_AND) begin : g_and
        assign cond = &term;
    end else begin : g_or
        assign cond = |term;
    end

    // Count consecutive true cycles, saturating at the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!cond)             cnt <= '0;
        else if (cnt != CW'(HOLD))  cnt <= cnt + 1'b1;
    end

    assign req = (cnt == CW'(HOLD));
endmodule

// File: rtl/inport_cond.sv
// Input pin conditioner top: synchronizer, debouncer, edge flags,
// counter clock taps and programmable reset request.
// Assumes NPINS >= 2 and deb_tick is a single-cycle pulse per debouncer period.
module inport_cond #(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit RST_USE_AND = 1'b1,
    parameter int RST_HOLD    = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_raw,
    input  logic                 deb_tick,
    input  logic [NPINS-1:0]     cfg_deb_en,
    input  logic [NPINS-1:0]     cfg_edge_fall,
    input  logic [NPINS-1:0]     cfg_mask_open,
    input  logic [2*NPINS-1:0]   cfg_rst_sel,
    input  logic                 wr_en,
    input  logic [NPINS-1:0]     wr_data,
    output logic [NPINS-1:0]     irq_flag,
    output logic                 irq_any,
    output logic [1:0]           test_var,
    output logic [1:0]           cnt_tap,
    output logic                 rst_req
);
    localparam int TAP_HI = NPINS - 1;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_deb;
    logic [NPINS-1:0] pin_cond;
    logic [NPINS-1:0] pin_pol;
    logic             rst_cond;

    inport_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
    );

    inport_debounce #(.W(NPINS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(deb_tick), .din(pin_sync), .dout(pin_deb)
    );

    // Per-pin choice between debounced and direct level.
    assign pin_cond = (cfg_deb_en & pin_deb) | (~cfg_deb_en & pin_sync);

    inport_edge_flags #(.W(NPINS)) u_flags (
        .clk(clk), .rst_n(rst_n), .level(pin_cond), .fall_sel(cfg_edge_fall),
        .mask_open(cfg_mask_open), .clr_en(wr_en), .clr_data(wr_data),
        .pol(pin_pol), .flags(irq_flag)
    );

    inport_rst_comb #(.W(NPINS), .USE_AND(RST_USE_AND), .HOLD(RST_HOLD)) u_rst (
        .clk(clk), .rst_n(rst_n), .level(pin_sync), .sel(cfg_rst_sel),
        .cond(rst_cond), .req(rst_req)
    );

    assign irq_any  = |(irq_flag & cfg_mask_open);
    assign test_var = pin_deb[1:0];
    assign cnt_tap  = {pin_pol[TAP_HI], pin_pol[0]};
endmodule

// File: rtl/inport_cond_chk.sv
// Assertion checker for inport_cond, attached by bind below.
// Checks flag set/clear causes, the combined line and the reset hold window.
module inport_cond_chk #(
    parameter int NPINS    = 4,
    parameter int RST_HOLD = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             deb_tick,
    input logic [NPINS-1:0] irq_flag,
    input logic             irq_any,
    input logic [NPINS-1:0] cfg_mask_open,
    input logic             wr_en,
    input logic [NPINS-1:0] wr_data,
    input logic [1:0]       test_var,
    input logic             rst_cond,
    input logic             rst_req
);
    localparam int CW = $clog2(RST_HOLD + 1);

    logic [CW-1:0] run;

    // Independent count of consecutive cycles with the reset condition true.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run <= '0;
        else if (!rst_cond)            run <= '0;
        else if (run != CW'(RST_HOLD)) run <= run + 1'b1;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_bit
        a_r5_set_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_flag[g]) |-> $past(cfg_mask_open[g]));
        a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_flag[g]) |-> $past(wr_en && wr_data[g]));
    end

    a_r7_any_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_flag != '0));

    a_r2_tv_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(deb_tick) |-> $stable(test_var));

    a_r12_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run == CW'(RST_HOLD)));
endmodule

bind inport_cond inport_cond_chk #(.NPINS(NPINS), .RST_HOLD(RST_HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .deb_tick(deb_tick), .irq_flag(irq_flag),
    .irq_any(irq_any), .cfg_mask_open(cfg_mask_open), .wr_en(wr_en),
    .wr_data(wr_data), .test_var(test_var), .rst_cond(rst_cond), .rst_req(rst_req)
);

// File: tb/inport_cond_test.sv
// Bench for inport_cond: reset combination table, then directed scenarios.
module inport_cond_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;
    localparam int NV         = 12;

    // {sel[7:0], pins[3:0], expect AND, expect OR}
    localparam logic [13:0] VEC [NV] = '{
        {8'hFF, 4'b0000, 1'b1, 1'b1},
        {8'h00, 4'b0000, 1'b0, 1'b0},
        {8'hFD, 4'b0001, 1'b1, 1'b1},
        {8'hFD, 4'b0000, 1'b0, 1'b1},
        {8'hFE, 4'b0000, 1'b1, 1'b1},
        {8'hFE, 4'b0001, 1'b0, 1'b1},
        {8'h55, 4'b1111, 1'b1, 1'b1},
        {8'h55, 4'b0111, 1'b0, 1'b1},
        {8'hAA, 4'b0000, 1'b1, 1'b1},
        {8'hAA, 4'b0100, 1'b0, 1'b1},
        {8'h55, 4'b0000, 1'b0, 1'b0},
        {8'h01, 4'b0001, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_raw = '0;
    logic       deb_tick = 1'b0;
    logic [3:0] cfg_deb_en = '0, cfg_edge_fall = '0, cfg_mask_open = '0;
    logic [7:0] cfg_rst_sel = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] irq_flag, irq_flag_o;
    logic       irq_any, irq_any_o;
    logic [1:0] test_var, test_var_o, cnt_tap, cnt_tap_o;
    logic       rst_req, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inport_cond #(.RST_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .deb_tick(deb_tick),
        .cfg_deb_en(cfg_deb_en), .cfg_edge_fall(cfg_edge_fall),
        .cfg_mask_open(cfg_mask_open), .cfg_rst_sel(cfg_rst_sel),
        .wr_en(wr_en), .wr_data(wr_data), .irq_flag(irq_flag), .irq_any(irq_any),
        .test_var(test_var), .cnt_tap(cnt_tap), .rst_req(rst_req)
    );

    inport_cond #(.RST_HOLD(HOLD), .RST_USE_AND(1'b0)) uut_or (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .deb_tick(deb_tick),
        .cfg_deb_en(cfg_deb_en), .cfg_edge_fall(cfg_edge_fall),
        .cfg_mask_open(cfg_mask_open), .cfg_rst_sel(cfg_rst_sel),
        .wr_en(wr_en), .wr_data(wr_data), .irq_flag(irq_flag_o), .irq_any(irq_any_o),
        .test_var(test_var_o), .cnt_tap(cnt_tap_o), .rst_req(rst_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pins(input logic [3:0] v);
        @(negedge clk);
        pin_raw = v;
    endtask

    task automatic tick();
        @(negedge clk);
        deb_tick = 1'b1;
        @(negedge clk);
        deb_tick = 1'b0;
        #1;
    endtask

    task automatic w1c(input logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R13 flags", 32'(irq_flag), 0);
        chk("R13 irq_any", 32'(irq_any), 0);
        chk("R13 test_var", 32'(test_var), 0);
        chk("R13 rst_req", 32'(rst_req), 0);

        // Reset combination table under AND and OR joining (R10, R11)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_rst_sel = VEC[v][13:6];
            pin_raw     = VEC[v][5:2];
            cyc(HOLD + 4);
            chk($sformatf("R10 R11 and vec%0d", v), 32'(rst_req), 32'(VEC[v][1]));
            chk($sformatf("R10 R11 or vec%0d", v), 32'(rst_req_o), 32'(VEC[v][0]));
        end

        @(negedge clk);
        cfg_rst_sel = '0;
        pin_raw = '0;
        cyc(4);
        tick();
        tick();

        // R12: exact hold window and release
        @(negedge clk);
        cfg_rst_sel = 8'hFF;
        cyc(HOLD - 1);
        chk("R12 before hold", 32'(rst_req), 0);
        cyc(1);
        chk("R12 at hold", 32'(rst_req), 1);
        @(negedge clk);
        cfg_rst_sel = 8'h00;
        cyc(1);
        chk("R12 release", 32'(rst_req), 0);

        // R1 bypass latency, R7 combined line
        @(negedge clk);
        cfg_mask_open = 4'hF;
        pins(4'b0001);
        cyc(2);
        chk("R1 not yet", 32'(irq_flag[0]), 0);
        cyc(1);
        chk("R1 flag set", 32'(irq_flag[0]), 1);
        chk("R7 any high", 32'(irq_any), 1);

        // R6 write-one-to-clear
        w1c(4'b0000);
        chk("R6 zero write", 32'(irq_flag[0]), 1);
        w1c(4'b0001);
        chk("R6 one write", 32'(irq_flag[0]), 0);
        chk("R7 any low", 32'(irq_any), 0);

        // R8 spurious request from polarity change with pin low
        @(negedge clk);
        cfg_edge_fall = 4'b0010;
        cyc(1);
        chk("R8 spurious", 32'(irq_flag[1]), 1);
        w1c(4'b0010);

        // R4 falling select ignores rise, takes fall
        pins(4'b0011);
        cyc(4);
        chk("R4 rise ignored", 32'(irq_flag[1]), 0);
        pins(4'b0001);
        cyc(4);
        chk("R4 fall taken", 32'(irq_flag[1]), 1);
        w1c(4'hF);

        // R9 counter taps
        @(negedge clk);
        cfg_edge_fall = 4'b1010;
        cyc(2);
        chk("R9 taps inverted top", 32'(cnt_tap), 2'b11);
        pins(4'b1001);
        cyc(4);
        chk("R9 taps top high", 32'(cnt_tap), 2'b01);
        @(negedge clk);
        cfg_edge_fall = 4'b0000;
        pin_raw = 4'b0001;
        cyc(4);
        w1c(4'hF);

        // R5 masked edge is not stored, opening mask picks nothing up
        @(negedge clk);
        cfg_mask_open = 4'b1011;
        pins(4'b0101);
        cyc(4);
        chk("R5 masked edge", 32'(irq_flag[2]), 0);
        @(negedge clk);
        cfg_mask_open = 4'hF;
        cyc(2);
        chk("R5 open no retro", 32'(irq_flag[2]), 0);
        pins(4'b0001);
        cyc(4);
        pins(4'b0101);
        cyc(4);
        chk("R5 next edge", 32'(irq_flag[2]), 1);
        @(negedge clk);
        cfg_mask_open = 4'b1011;
        cyc(1);
        chk("R7 masked flag kept", 32'(irq_flag[2]), 1);
        chk("R7 masked any low", 32'(irq_any), 0);
        @(negedge clk);
        cfg_mask_open = 4'hF;
        w1c(4'hF);

        // R3 test vars debounced even in bypass; R2 two-tick acceptance
        tick();
        chk("R3 tv one tick", 32'(test_var[0]), 0);
        tick();
        chk("R2 tv two ticks", 32'(test_var[0]), 1);
        pins(4'b0111);
        cyc(4);
        tick();
        pins(4'b0101);
        cyc(4);
        tick();
        chk("R2 glitch rejected", 32'(test_var[1]), 0);

        // R2 debounced interrupt path
        @(negedge clk);
        cfg_deb_en = 4'b0100;
        pins(4'b0001);
        cyc(4);
        tick();
        tick();
        w1c(4'hF);
        pins(4'b0101);
        cyc(4);
        chk("R2 deb hold", 32'(irq_flag[2]), 0);
        tick();
        chk("R2 deb one tick", 32'(irq_flag[2]), 0);
        tick();
        cyc(1);
        chk("R2 deb accepted", 32'(irq_flag[2]), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule